// File: doc/BRIEF.md
# Truncated-Seconds Timestamp Extender

This block takes a hardware timestamp that holds only the two least significant bits of the seconds count and a 30-bit nanoseconds count, and rebuilds the full seconds value from a reference reading of the local clock's seconds counter. The reference is taken near the moment of capture, but it may be a little before or a little after it. The block therefore looks for a seconds value within one second either side of the reference whose low bits agree with the captured bits.

A captured nanoseconds count can be one billion or more. In that case it is first folded back into range, and the carry goes into the short seconds field before the search starts. The result is either the rebuilt full time or an error flag. The error means that no candidate in the window fits, so the capture is too far from the reference to be trusted.

Requests enter and results leave through a valid/ready pair. A single result register sits between them, so a new request is taken whenever that register is empty or is being drained in the same cycle.

Top module: `ts_sec_extender`

## Requirements
- R1: After reset, `outValid` is 0 and `inReady` is 1.
- R2: The captured word carries the short seconds in bits [31:30] and the nanoseconds in bits [29:0]. The nanoseconds field is made of a high part in [29:16] and a low part in [15:0], and the two are used together as one value.
- R3: When the captured nanoseconds are at least 1,000,000,000, the block subtracts 10^9 from them and adds 1 to the 2-bit seconds, wrapping modulo 4, before any matching.
- R4: When the low 2 bits of `refSec` equal the normalised short seconds, `outSec` is `refSec`.
- R5: Otherwise the block tries `refSec`-1 and then `refSec`+1, using 48-bit arithmetic, and outputs the first candidate whose low 2 bits match.
- R6: When no candidate matches, `outErr` is 1 and both `outSec` and `outNsec` are 0.
- R7: When `refSec` is 0, `refSec`-1 is not a candidate. When `refSec` is all ones, `refSec`+1 is not a candidate. Either case can raise the error.
- R8: `outValid` rises in the cycle after a request is accepted. `inReady` is high exactly when `outValid` is low or `outReady` is high.
- R9: While `outValid` is high and `outReady` is low, `outValid`, `outSec`, `outNsec` and `outErr` hold their values, and no request is accepted.
- R10: A successful result has `outNsec` below 10^9, and its nanoseconds fit in 30 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Request can be taken this cycle |
| capWord | input | 32 | Captured short timestamp |
| refSec | input | 48 | Reference full seconds |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Consumer takes the result |
| outSec | output | 48 | Rebuilt full seconds |
| outNsec | output | 30 | Normalised nanoseconds |
| outErr | output | 1 | No candidate matched |

## Verification
On every cycle the assertions check several rules. A result lies within one second of the reference it was computed from, and its low bits agree with the normalised short seconds. Error results carry zero data, and nanoseconds stay in range. Valid follows acceptance by one cycle, and a stalled result holds steady.

Some behaviours can only be shown by the bench's chosen inputs. These are the exact order of preference among the three candidates and the carry from an out-of-range nanoseconds count, including its wrap from 3 to 0. They also include the edge cases at a zero reference and at an all-ones reference, and the correct reading of the captured word's field layout.

// File: rtl/ts_sec_extender_pkg.sv
package ts_sec_extender_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
  } tsxStrobe_t;

  // candidate offsets searched, in order of preference
  localparam int NUM_CAND = 3;

endpackage

// File: rtl/tsx_control.sv
module tsx_control
  import ts_sec_extender_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output tsxStrobe_t str
);

  logic accept;

  assign inReady  = !outValid || outReady;
  assign accept   = inValid && inReady;
  assign str.load = accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
    end else if (accept) begin
      outValid <= 1'b1;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  // R8: a taken request shows up as valid output one cycle later
  a_r8_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady) |=> outValid);

  // R9: a stalled result stays valid
  a_r9_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> outValid);

endmodule

// File: rtl/tsx_datapath.sv
module tsx_datapath
  import ts_sec_extender_pkg::*;
#(
  parameter int SEC_W      = 48,
  parameter int CAP_SEC_W  = 2,
  parameter int NS_W       = 30,
  parameter int NS_PER_SEC = 1000000000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  tsxStrobe_t                    str,
  input  logic [CAP_SEC_W+NS_W-1:0]     capWord,
  input  logic [SEC_W-1:0]              refSec,
  output logic [SEC_W-1:0]              outSec,
  output logic [NS_W-1:0]               outNsec,
  output logic                          outErr
);

  localparam int CAP_W = CAP_SEC_W + NS_W;
  localparam logic [NS_W-1:0]  NS_LIMIT = NS_W'(NS_PER_SEC);
  localparam logic [SEC_W-1:0] SEC_ONE  = SEC_W'(1);
  localparam logic [SEC_W-1:0] SEC_MAX  = {SEC_W{1'b1}};

  logic [CAP_SEC_W-1:0] capSec;
  logic [NS_W-1:0]      capNs;
  logic                 overRange;
  logic [NS_W-1:0]      normNs;
  logic [CAP_SEC_W-1:0] normSec;

  assign capSec    = capWord[CAP_W-1 -: CAP_SEC_W];
  assign capNs     = capWord[NS_W-1:0];
  assign overRange = (capNs >= NS_LIMIT);
  assign normNs    = overRange ? (capNs - NS_LIMIT) : capNs;
  assign normSec   = capSec + CAP_SEC_W'(overRange);

  logic [SEC_W-1:0] candSec [NUM_CAND];
  logic [NUM_CAND-1:0] candOk;
  logic [NUM_CAND-1:0] candHit;

  for (genvar i = 0; i < NUM_CAND; i++) begin : g_cand
    if (i == 0) begin : g_same
      assign candSec[i] = refSec;
      assign candOk[i]  = 1'b1;
    end else if (i == 1) begin : g_before
      assign candSec[i] = refSec - SEC_ONE;
      assign candOk[i]  = (refSec != '0);
    end else begin : g_after
      assign candSec[i] = refSec + SEC_ONE;
      assign candOk[i]  = (refSec != SEC_MAX);
    end
    assign candHit[i] = candOk[i] && (candSec[i][CAP_SEC_W-1:0] == normSec);
  end

  logic [SEC_W-1:0] selSec;
  logic             anyHit;

  always_comb begin
    selSec = '0;
    anyHit = |candHit;
    for (int k = NUM_CAND - 1; k >= 0; k--) begin
      if (candHit[k]) selSec = candSec[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outSec  <= '0;
      outNsec <= '0;
      outErr  <= 1'b0;
    end else if (str.load) begin
      if (anyHit) begin
        outSec  <= selSec;
        outNsec <= normNs;
        outErr  <= 1'b0;
      end else begin
        outSec  <= '0;
        outNsec <= '0;
        outErr  <= 1'b1;
      end
    end
  end

  // R6: an error result carries no timestamp
  a_r6_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    outErr |-> (outSec == '0 && outNsec == '0));

  // R10: nanoseconds stay below one second
  a_r10_ns_range: assert property (@(posedge clk) disable iff (!rst_n)
    outNsec < NS_LIMIT);

  // R5: a good result is within one second of its reference
  a_r5_window: assert property (@(posedge clk) disable iff (!rst_n)
    str.load |=> (outErr || outSec == $past(refSec)
                  || outSec == $past(refSec) - SEC_ONE
                  || outSec == $past(refSec) + SEC_ONE));

  // R3: low seconds bits of a good result match the normalised capture
  a_r3_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    str.load |=> (outErr || outSec[CAP_SEC_W-1:0] == $past(normSec)));

endmodule

// File: rtl/ts_sec_extender.sv
module ts_sec_extender
  import ts_sec_extender_pkg::*;
#(
  parameter int SEC_W      = 48,
  parameter int CAP_SEC_W  = 2,
  parameter int NS_W       = 30,
  parameter int NS_PER_SEC = 1000000000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      inValid,
  output logic                      inReady,
  input  logic [CAP_SEC_W+NS_W-1:0] capWord,
  input  logic [SEC_W-1:0]          refSec,
  output logic                      outValid,
  input  logic                      outReady,
  output logic [SEC_W-1:0]          outSec,
  output logic [NS_W-1:0]           outNsec,
  output logic                      outErr
);

  tsxStrobe_t str;

  tsx_control u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .str      (str)
  );

  tsx_datapath #(
    .SEC_W      (SEC_W),
    .CAP_SEC_W  (CAP_SEC_W),
    .NS_W       (NS_W),
    .NS_PER_SEC (NS_PER_SEC)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .str     (str),
    .capWord (capWord),
    .refSec  (refSec),
    .outSec  (outSec),
    .outNsec (outNsec),
    .outErr  (outErr)
  );

  // R9: a stalled result does not change
  a_r9_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> ($stable(outSec) && $stable(outNsec) && $stable(outErr)));

endmodule

// File: tb/ts_sec_extender_test.sv
module ts_sec_extender_test;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [23:0] tag;
    logic [31:0] cap;
    logic [47:0] refS;
    logic [47:0] eSec;
    logic [29:0] eNs;
    logic        eErr;
  } vec_t;

  localparam logic [47:0] ONES = 48'hFFFF_FFFF_FFFF;
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{"R4 ", {2'd1, 30'd500},        48'd5, 48'd5, 30'd500, 1'b0},
    '{"R5 ", {2'd0, 30'd7},          48'd5, 48'd4, 30'd7,   1'b0},
    '{"R5 ", {2'd2, 30'd7},          48'd5, 48'd6, 30'd7,   1'b0},
    '{"R6 ", {2'd3, 30'd7},          48'd5, 48'd0, 30'd0,   1'b1},
    '{"R3 ", {2'd1, 30'd1000000000}, 48'd5, 48'd6, 30'd0,   1'b0},
    '{"R3 ", {2'd3, 30'd1000000123}, 48'd4, 48'd4, 30'd123, 1'b0},
    '{"R7 ", {2'd3, 30'd9},          48'd0, 48'd0, 30'd0,   1'b1},
    '{"R7 ", {2'd2, 30'd9},          48'd0, 48'd0, 30'd0,   1'b1},
    '{"R4 ", {2'd0, 30'd9},          48'd0, 48'd0, 30'd9,   1'b0},
    '{"R7 ", {2'd0, 30'd9},          ONES,  48'd0, 30'd0,   1'b1},
    '{"R5 ", {2'd2, 30'd11},         ONES,  ONES - 48'd1, 30'd11, 1'b0},
    '{"R10", {2'd0, 30'h3FFF_FFFF},  48'd1, 48'd1, 30'd73741823, 1'b0},
    '{"R2 ", {2'd2, 30'h2ABC_1234},  48'd10, 48'd10, 30'h2ABC_1234, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] capWord = '0;
  logic [47:0] refSec = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [47:0] outSec;
  logic [29:0] outNsec;
  logic        outErr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ts_sec_extender uut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .capWord(capWord), .refSec(refSec), .outValid(outValid),
    .outReady(outReady), .outSec(outSec), .outNsec(outNsec), .outErr(outErr)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chkResult(input string req, input logic [47:0] s,
                           input logic [29:0] n, input logic e);
    chk(req, "outValid", 64'(outValid), 64'd1);
    chk(req, "outSec", 64'(outSec), 64'(s));
    chk(req, "outNsec", 64'(outNsec), 64'(n));
    chk(req, "outErr", 64'(outErr), 64'(e));
  endtask

  // send one request with the consumer ready, check one cycle later
  task automatic runOne(input string req, input logic [31:0] c, input logic [47:0] r,
                        input logic [47:0] s, input logic [29:0] n, input logic e);
    @(negedge clk);
    outReady = 1'b1;
    inValid  = 1'b1;
    capWord  = c;
    refSec   = r;
    @(negedge clk);
    inValid  = 1'b0;
    chkResult(req, s, n, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "outValid", 64'(outValid), 64'd0);
    chk("R1", "inReady", 64'(inReady), 64'd1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      runOne($sformatf("%s", VECS[i].tag), VECS[i].cap, VECS[i].refS,
             VECS[i].eSec, VECS[i].eNs, VECS[i].eErr);
    end

    // R8: valid drops once consumed with nothing new
    @(negedge clk);
    chk("R8", "outValid idle", 64'(outValid), 64'd0);

    // R9: backpressure holds result and blocks intake
    outReady = 1'b0;
    inValid  = 1'b1;
    capWord  = {2'd1, 30'd42};
    refSec   = 48'd9;
    @(negedge clk);
    chk("R8", "inReady stalled", 64'(inReady), 64'd0);
    capWord  = {2'd0, 30'd77};
    refSec   = 48'd100;
    @(negedge clk);
    chk("R9", "held outSec", 64'(outSec), 64'd9);
    chk("R9", "held outNsec", 64'(outNsec), 64'd42);
    chk("R9", "held outValid", 64'(outValid), 64'd1);
    outReady = 1'b1;
    @(negedge clk);
    inValid  = 1'b0;
    chkResult("R8", 48'd100, 30'd77, 1'b0);

    // R8: back-to-back requests every cycle
    inValid = 1'b1;
    capWord = {2'd3, 30'd5};
    refSec  = 48'd7;
    @(negedge clk);
    chkResult("R8", 48'd7, 30'd5, 1'b0);
    capWord = {2'd1, 30'd6};
    refSec  = 48'd8;
    @(negedge clk);
    inValid = 1'b0;
    chkResult("R8", 48'd9, 30'd6, 1'b0);

    // R1: reset while a result is pending
    outReady = 1'b0;
    inValid  = 1'b1;
    @(negedge clk);
    inValid  = 1'b0;
    rst_n    = 1'b0;
    @(negedge clk);
    chk("R1", "outValid after reset", 64'(outValid), 64'd0);
    chk("R1", "inReady after reset", 64'(inReady), 64'd1);
    rst_n    = 1'b1;
    outReady = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule